// File: doc/BRIEF.md
# Timer Tick Generator with Prescalers and Source Select

This block turns one system clock into five single-cycle count-enable ticks, one for each channel of a PWM timer. Two 8-bit prescalers each emit a strobe every (P+1) system cycles. The first prescaler feeds channels 0 and 1. The second feeds channels 2, 3 and 4. Each channel then applies its own power-of-two divider to its strobe, or follows an external clock input that is already synchronized, as chosen by a 4-bit select field.

Two configuration words arrive on plain write ports from a register bank. Word 0 carries both prescaler values. Word 1 carries the five select fields. Two parameters set how a select code is decoded. A divider base offsets the power-of-two exponent. An external mask marks the codes that choose the external clock. The default build uses base 1 with code 4 as the external code. A second build uses base 0 with codes 5, 6 and 7 as external codes. Any write restarts every prescaler and divider, so the first tick after programming arrives at a known cycle. Each tick is meant to be used as a clock enable by the downstream counters.

Top module: `tmr_tick_gen`

## Requirements
- R1: A clock edge taken with `rst` high leaves every tick low in the next cycle. Reset clears the prescaler values and the select fields to zero. After release, the channels tick as R4 gives for code 0 and prescaler 0, with the last reset edge counted as the restart edge.
- R2: Word 0 bits 7:0 set prescaler P0, which serves channels 0 and 1. Bits 15:8 set P1, which serves channels 2 to 4. A prescaler strobes once every P+1 system cycles.
- R3: Word 1 bits 4n+3:4n form the select field of channel n.
- R4: Take a code c that is not in the mask, and let s = c + DIV_BASE with s ≤ 4. Cycle 0 is the cycle right after the restart edge. The tick is high in exactly the cycles k = j·2^s·(P+1), for j ≥ 1.
- R5: A write to either word restarts both prescalers and all five dividers. Every tick is low in the cycle right after the write edge.
- R6: A code in EXT_MASK selects an external input: ext_clk0 for channels 0 and 1, ext_clk1 for channels 2 to 4. Suppose the input is sampled high at edge E after being sampled low at the edge before. The tick is then high for exactly the one cycle after E, unless E is a restart edge.
- R7: A code that is neither in the mask nor a divider code (c + DIV_BASE > 4) holds its tick low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg0_we | input | 1 | Write strobe for prescaler word |
| cfg0_wdata | input | 16 | Prescaler word: P1 in 15:8, P0 in 7:0 |
| cfg1_we | input | 1 | Write strobe for select word |
| cfg1_wdata | input | 20 | Select word: 4 bits per channel |
| ext_clk0 | input | 1 | Synchronized external clock for channels 0–1 |
| ext_clk1 | input | 1 | Synchronized external clock for channels 2–4 |
| tick_o | output | 5 | Per-channel single-cycle count enable |

## Verification
A divider tick is due a whole number of periods 2^s·(P+1) after the write edge. No tick can appear in cycle 0, because the output register adds one cycle to the strobe comparison. An external tick is due one cycle after the edge that first samples the input high. The bench sets up both variants and every select code on every channel, under several pairs of prescaler values. It counts cycles from the write edge and samples on the falling edge, so each expected value is computed for the exact cycle in which the register updates. It keeps a two-deep history of the external levels it has driven, so the expected edge tick is tied to the same cycle. A second write of word 1 alone, at an unaligned moment, checks that phase restarts from that write.

// File: rtl/tmr_tick_pkg.sv
package tmr_tick_pkg;

    localparam int SEL_W     = 4;
    localparam int MAX_SHIFT = 4;
    localparam int SHIFT_W   = $clog2(MAX_SHIFT + 1);
    localparam int CODE_N    = 1 << SEL_W;

    typedef enum logic [1:0] {
        SRC_OFF = 2'd0,
        SRC_DIV = 2'd1,
        SRC_EXT = 2'd2
    } src_e;

    typedef struct packed {
        src_e               src;
        logic [SHIFT_W-1:0] shift;
    } route_t;

    // Map a select code to a tick source and a divider exponent.
    function automatic route_t decode_sel(
        input logic [SEL_W-1:0]  code,
        input int                div_base,
        input logic [CODE_N-1:0] ext_mask
    );
        route_t r;
        int     total;
        r.src   = SRC_OFF;
        r.shift = '0;
        total   = int'(code) + div_base;
        if (ext_mask[code]) begin
            r.src = SRC_EXT;
        end else if (total <= MAX_SHIFT) begin
            r.src   = SRC_DIV;
            r.shift = SHIFT_W'(total);
        end
        return r;
    endfunction

endpackage

// File: rtl/tmr_psc.sv
module tmr_psc #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic [W-1:0] div_val,
    output logic         stb
);

    logic [W-1:0] cnt_q;

    assign stb = (cnt_q == div_val);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (stb) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= div_val);

    // R2
    stb_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (stb && div_val != '0 && !restart) |=> !stb);

endmodule

// File: rtl/tmr_edge.sv
module tmr_edge (
    input  logic clk,
    input  logic ext_i,
    output logic rise_o
);

    logic ext_d;

    // Tracks the input even during reset so a level held high gives no tick.
    always_ff @(posedge clk) begin
        ext_d <= ext_i;
    end

    assign rise_o = ext_i & ~ext_d;

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_tick_pkg::*;
#(
    parameter int                DIV_BASE = 1,
    parameter logic [CODE_N-1:0] EXT_MASK = 16'h0010
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    input  logic             stb_i,
    input  logic             rise_i,
    output logic             tick_o
);

    route_t               rt;
    logic [MAX_SHIFT:0]   one_hot;
    logic [MAX_SHIFT-1:0] low_mask;
    logic [MAX_SHIFT-1:0] dcnt_q;
    logic                 div_hit;
    logic                 tick_next;

    assign rt       = decode_sel(sel, DIV_BASE, EXT_MASK);
    assign one_hot  = {{MAX_SHIFT{1'b0}}, 1'b1} << rt.shift;
    assign low_mask = one_hot[MAX_SHIFT-1:0] - 1'b1;
    assign div_hit  = stb_i && ((dcnt_q & low_mask) == low_mask);

    always_comb begin
        tick_next = 1'b0;
        if (!restart) begin
            case (rt.src)
                SRC_DIV: tick_next = div_hit;
                SRC_EXT: tick_next = rise_i;
                default: tick_next = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            dcnt_q <= '0;
        end else if (stb_i) begin
            dcnt_q <= dcnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_o <= 1'b0;
        end else begin
            tick_o <= tick_next;
        end
    end

    // R4
    tick_origin_chk: assert property (@(posedge clk) disable iff (rst)
        tick_o |-> $past(stb_i || rise_i));

    // R5
    restart_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(restart) |-> !tick_o);

    // R7
    off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (rt.src == SRC_OFF && $past(rt.src == SRC_OFF)) |-> !tick_o);

endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
    import tmr_tick_pkg::*;
#(
    parameter int                CH_N      = 5,
    parameter int                GRP_SPLIT = 2,
    parameter int                PSC_W     = 8,
    parameter int                DIV_BASE  = 1,
    parameter logic [CODE_N-1:0] EXT_MASK  = 16'h0010
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg0_we,
    input  logic [2*PSC_W-1:0]     cfg0_wdata,
    input  logic                   cfg1_we,
    input  logic [CH_N*SEL_W-1:0]  cfg1_wdata,
    input  logic                   ext_clk0,
    input  logic                   ext_clk1,
    output logic [CH_N-1:0]        tick_o
);

    localparam int GRP_N = 2;

    logic [PSC_W-1:0] psc_q [GRP_N];
    logic [SEL_W-1:0] sel_q [CH_N];
    logic             restart;
    logic [GRP_N-1:0] stb_w;
    logic [GRP_N-1:0] rise_w;
    logic [GRP_N-1:0] ext_in;

    assign restart = cfg0_we | cfg1_we;
    assign ext_in  = {ext_clk1, ext_clk0};

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int g = 0; g < GRP_N; g++) psc_q[g] <= '0;
        end else if (cfg0_we) begin
            for (int g = 0; g < GRP_N; g++) psc_q[g] <= cfg0_wdata[g*PSC_W +: PSC_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < CH_N; c++) sel_q[c] <= '0;
        end else if (cfg1_we) begin
            for (int c = 0; c < CH_N; c++) sel_q[c] <= cfg1_wdata[c*SEL_W +: SEL_W];
        end
    end

    for (genvar g = 0; g < GRP_N; g++) begin : g_grp
        tmr_psc #(.W(PSC_W)) u_psc (
            .clk     (clk),
            .rst     (rst),
            .restart (restart),
            .div_val (psc_q[g]),
            .stb     (stb_w[g])
        );
        tmr_edge u_edge (
            .clk    (clk),
            .ext_i  (ext_in[g]),
            .rise_o (rise_w[g])
        );
    end

    for (genvar c = 0; c < CH_N; c++) begin : g_ch
        localparam int GRP = (c < GRP_SPLIT) ? 0 : 1;
        tmr_chan #(.DIV_BASE(DIV_BASE), .EXT_MASK(EXT_MASK)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .restart (restart),
            .sel     (sel_q[c]),
            .stb_i   (stb_w[GRP]),
            .rise_i  (rise_w[GRP]),
            .tick_o  (tick_o[c])
        );
    end

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (tick_o == '0));

endmodule

// File: tb/tmr_tick_gen_test.sv
module tmr_tick_gen_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg0_we = 1'b0;
    logic [15:0] cfg0_wdata = '0;
    logic        cfg1_we = 1'b0;
    logic [19:0] cfg1_wdata = '0;
    logic        ext_clk0 = 1'b0;
    logic        ext_clk1 = 1'b0;
    logic [4:0]  tick_a;
    logic [4:0]  tick_b;

    always #10 clk = ~clk;

    tmr_tick_gen uut (
        .clk(clk), .rst(rst), .cfg0_we(cfg0_we), .cfg0_wdata(cfg0_wdata),
        .cfg1_we(cfg1_we), .cfg1_wdata(cfg1_wdata),
        .ext_clk0(ext_clk0), .ext_clk1(ext_clk1), .tick_o(tick_a)
    );

    tmr_tick_gen #(.DIV_BASE(0), .EXT_MASK(16'h00E0)) uut_b (
        .clk(clk), .rst(rst), .cfg0_we(cfg0_we), .cfg0_wdata(cfg0_wdata),
        .cfg1_we(cfg1_we), .cfg1_wdata(cfg1_wdata),
        .ext_clk0(ext_clk0), .ext_clk1(ext_clk1), .tick_o(tick_b)
    );

    int    vectors = 0;
    int    fails   = 0;
    int    cyc     = 0;
    int    psc_lo  = 0;
    int    psc_hi  = 0;
    int    code [5];
    bit    [1:0] drv = 2'b00;
    bit    [1:0] old = 2'b00;
    string tag   = "";
    bit    done  = 1'b0;

    function automatic bit exp_tick(input int base, input int mask, input int c,
                                    input int k, input int psc, input bit d, input bit o);
        if (k == 0) return 1'b0;
        if (((mask >> c) & 1) == 1) return d & ~o;
        if (c + base <= 4) return (k % ((1 << (c + base)) * (psc + 1))) == 0;
        return 1'b0;
    endfunction

    function automatic string req_of(input int base, input int mask, input int c);
        if (((mask >> c) & 1) == 1) return "R3 R6";
        if (c + base <= 4) return "R2 R3 R4";
        return "R3 R7";
    endfunction

    task automatic step(input bit chk, input int k);
        @(negedge clk);
        cfg0_we = 1'b0;
        cfg1_we = 1'b0;
        if (chk) begin
            for (int v = 0; v < 2; v++) begin
                int base = (v == 0) ? 1 : 0;
                int mask = (v == 0) ? 32'h10 : 32'hE0;
                for (int ch = 0; ch < 5; ch++) begin
                    int    grp = (ch < 2) ? 0 : 1;
                    int    psc = (ch < 2) ? psc_lo : psc_hi;
                    bit    exp = exp_tick(base, mask, code[ch], k, psc, drv[grp], old[grp]);
                    bit    act = (v == 0) ? tick_a[ch] : tick_b[ch];
                    string rq  = (tag != "") ? tag : req_of(base, mask, code[ch]);
                    vectors++;
                    if (act !== exp) begin
                        fails++;
                        $display("FAIL %s var%0d ch%0d code%0d k=%0d actual=%0b expected=%0b",
                                 rq, v, ch, code[ch], k, act, exp);
                    end
                end
            end
        end
        cyc++;
        old = drv;
        if (cyc % 3 == 0) drv[0] = ~drv[0];
        if (cyc % 5 == 0 || cyc % 7 == 0) drv[1] = ~drv[1];
        ext_clk0 = drv[0];
        ext_clk1 = drv[1];
    endtask

    task automatic write_cfg(input bit w0, input bit w1);
        cfg0_wdata = {psc_hi[7:0], psc_lo[7:0]};
        // R3: field n occupies bits 4n+3:4n
        for (int ch = 0; ch < 5; ch++) cfg1_wdata[ch*4 +: 4] = code[ch][3:0];
        cfg0_we = w0;
        cfg1_we = w1;
    endtask

    initial begin
        int pscs [4][2];
        pscs = '{'{0, 1}, '{2, 5}, '{3, 0}, '{1, 1}};
        for (int ch = 0; ch < 5; ch++) code[ch] = 0;
        // R1: ticks low while reset is applied
        tag = "R1";
        step(0, 0);
        step(1, 0);
        step(1, 0);
        rst = 1'b0;
        // R1: defaults after release, cycle count from the last reset edge
        for (int k = 1; k < 24; k++) step(1, k);
        tag = "";
        for (int p = 0; p < 4; p++) begin
            for (int b = 0; b < 16; b++) begin
                int win;
                psc_lo = pscs[p][0];
                psc_hi = pscs[p][1];
                for (int ch = 0; ch < 5; ch++) code[ch] = (b + 3 * ch) % 16;
                win = 2 * 16 * (((psc_lo > psc_hi) ? psc_lo : psc_hi) + 1) + 4;
                write_cfg(1'b1, 1'b1);
                for (int k = 0; k < win; k++) step(1, k);
                if (p == 1) begin
                    // R5: a lone select write at an unaligned moment restarts phase
                    for (int k = 0; k < 7; k++) step(0, 0);
                    write_cfg(1'b0, 1'b1);
                    tag = "R5";
                    for (int k = 0; k < win; k++) step(1, k);
                    tag = "";
                end
            end
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #3000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule